// File: doc/BRIEF.md
# Dual-Media Link Monitor and LED Stretcher

This block sits beside the two symbol paths of a back-to-back copper/fiber media converter. Each side supplies three inputs: a link-good level from its receiver, a one-cycle receive-activity strobe, and a one-cycle code-group-error strobe from its alignment monitor. The link levels come from another clock area, so a synchroniser re-times them before use. The block drives six active-low LED lines: link, activity and error for each side.

Each transmit direction forwards data received on the opposite medium. When that opposite medium has no link, the block tells the transmitter to send a fill symbol in place of the forwarded data. A static strap input chooses the fill symbol. With the strap low the fill symbol is Idle, so the far partner sees a quiet line. With the strap high the fill symbol is Halt, so the missing link is passed on to the far partner. Activity and error events are stretched by a retriggerable one-shot counter, so a single-cycle event still gives a visible pulse. While reset is held, every LED is driven on as a lamp test.

Top module: `media_link_watch`

## Requirements
- R1: A link LED (`led_cu_link_n`, `led_fb_link_n`) is low exactly when its side's synchronised link level is 1. A change on the raw link input reaches the LED after two rising clock edges.
- R2: A one-cycle activity strobe sampled at clock edge e drives that side's activity LED low from edge e to edge e+STRETCH_CYCLES. After that edge the LED returns high.
- R3: A new event that arrives while the LED is stretched restarts the count. The LED then stays low for STRETCH_CYCLES edges after the newest event.
- R4: A code-group-error strobe lights that side's error LED through the same one-shot timing as R2 and R3.
- R5: While `rst` is 1, all six LED outputs are 0 (lamp test), whatever the other inputs are.
- R6: `cu_fill_sel` is 1 while the synchronised fiber link is 0, and `fb_fill_sel` is 1 while the synchronised copper link is 0. Each follows the other side's raw link input after two edges.
- R7: Both fill symbol outputs carry Halt = 5'b00100 when `halt_sel` is 1 and Idle = 5'b11111 when `halt_sel` is 0.
- R8: Once reset is released, with no events and with both links down, every activity and error LED is high and both fill selects are 1.
- R9: The sides are independent. An event or link change on one side leaves the other side's activity, error and link LEDs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high; also the lamp-test request |
| cu_link_raw | input | 1 | Copper link-good level, asynchronous |
| fb_link_raw | input | 1 | Fiber link-good level, asynchronous |
| cu_rx_evt | input | 1 | Copper receive-activity strobe |
| fb_rx_evt | input | 1 | Fiber receive-activity strobe |
| cu_err_evt | input | 1 | Copper code-group-error strobe |
| fb_err_evt | input | 1 | Fiber code-group-error strobe |
| halt_sel | input | 1 | Fill choice: 1 = Halt, 0 = Idle |
| cu_fill_sel | output | 1 | Copper transmitter substitutes the fill symbol |
| cu_fill_sym | output | SYM_W | Fill symbol for the copper transmitter |
| fb_fill_sel | output | 1 | Fiber transmitter substitutes the fill symbol |
| fb_fill_sym | output | SYM_W | Fill symbol for the fiber transmitter |
| led_cu_link_n | output | 1 | Copper link LED, active low |
| led_fb_link_n | output | 1 | Fiber link LED, active low |
| led_cu_rx_n | output | 1 | Copper activity LED, active low |
| led_fb_rx_n | output | 1 | Fiber activity LED, active low |
| led_cu_err_n | output | 1 | Copper error LED, active low |
| led_fb_err_n | output | 1 | Fiber error LED, active low |

## Verification
The checker tests on every clock edge:
- that the lamp test holds during reset;
- that an event lights its LED on the next edge;
- that no stretched pulse outlives its window;
- that a link seen low two edges earlier always gives link LED off and fill selected on the opposite transmitter.

The bench scenarios show the rest:
- the exact stretch length, and the restart after a retrigger;
- the two-edge synchroniser delay;
- the Idle/Halt code values;
- the independence of the two sides.

// File: rtl/mlw_pkg.sv
package mlw_pkg;
   localparam int unsigned SIDES   = 2;
   localparam int unsigned SIDE_CU = 0;
   localparam int unsigned SIDE_FB = 1;
   // stretcher flavours instantiated per side
   localparam int unsigned KINDS   = 2;
   localparam int unsigned KIND_RX = 0;
   localparam int unsigned KIND_ER = 1;
endpackage

// File: rtl/mlw_sync.sv
module mlw_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mlw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mlw_stretch.sv
module mlw_stretch #(
   parameter int unsigned HOLD = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic evt,
   output logic active
);
   localparam int unsigned CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD);

   logic [CW-1:0] remain;

   always_ff @(posedge clk) begin
      if (rst)               remain <= '0;
      else if (evt)          remain <= LOAD;
      else if (remain != '0) remain <= remain - 1'b1;
   end

   assign active = (remain != '0);
endmodule

// File: rtl/media_link_watch.sv
module media_link_watch #(
   parameter int unsigned STRETCH_CYCLES = 1_250_000,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned SYM_W          = 5,
   parameter logic [SYM_W-1:0] IDLE_SYM  = 5'b11111,
   parameter logic [SYM_W-1:0] HALT_SYM  = 5'b00100
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cu_link_raw,
   input  logic             fb_link_raw,
   input  logic             cu_rx_evt,
   input  logic             fb_rx_evt,
   input  logic             cu_err_evt,
   input  logic             fb_err_evt,
   input  logic             halt_sel,
   output logic             cu_fill_sel,
   output logic [SYM_W-1:0] cu_fill_sym,
   output logic             fb_fill_sel,
   output logic [SYM_W-1:0] fb_fill_sym,
   output logic             led_cu_link_n,
   output logic             led_fb_link_n,
   output logic             led_cu_rx_n,
   output logic             led_fb_rx_n,
   output logic             led_cu_err_n,
   output logic             led_fb_err_n
);
   import mlw_pkg::*;

   if (STRETCH_CYCLES < 2) begin : g_bad_stretch
      $error("media_link_watch: STRETCH_CYCLES must be at least 2");
   end
   if (SYM_W < 3) begin : g_bad_symw
      $error("media_link_watch: SYM_W must be at least 3");
   end

   logic [SIDES-1:0]       link_raw, link_ok;
   logic [KINDS-1:0][SIDES-1:0] evt, lit;

   assign link_raw[SIDE_CU]      = cu_link_raw;
   assign link_raw[SIDE_FB]      = fb_link_raw;
   assign evt[KIND_RX][SIDE_CU]  = cu_rx_evt;
   assign evt[KIND_RX][SIDE_FB]  = fb_rx_evt;
   assign evt[KIND_ER][SIDE_CU]  = cu_err_evt;
   assign evt[KIND_ER][SIDE_FB]  = fb_err_evt;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      mlw_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst(rst), .d_async(link_raw[s]), .q_sync(link_ok[s])
      );
      for (genvar k = 0; k < KINDS; k++) begin : g_kind
         mlw_stretch #(.HOLD(STRETCH_CYCLES)) u_str (
            .clk(clk), .rst(rst), .evt(evt[k][s]), .active(lit[k][s])
         );
      end
   end

   // each transmitter fills when the opposite medium has no link
   logic [SYM_W-1:0] fill_code;
   assign fill_code   = halt_sel ? HALT_SYM : IDLE_SYM;
   assign cu_fill_sel = ~link_ok[SIDE_FB];
   assign fb_fill_sel = ~link_ok[SIDE_CU];
   assign cu_fill_sym = fill_code;
   assign fb_fill_sym = fill_code;

   // active-low LEDs, forced on while reset is held
   assign led_cu_link_n = ~(rst | link_ok[SIDE_CU]);
   assign led_fb_link_n = ~(rst | link_ok[SIDE_FB]);
   assign led_cu_rx_n   = ~(rst | lit[KIND_RX][SIDE_CU]);
   assign led_fb_rx_n   = ~(rst | lit[KIND_RX][SIDE_FB]);
   assign led_cu_err_n  = ~(rst | lit[KIND_ER][SIDE_CU]);
   assign led_fb_err_n  = ~(rst | lit[KIND_ER][SIDE_FB]);
endmodule

// File: rtl/mlw_checker.sv
module mlw_checker #(
   parameter int unsigned STRETCH_CYCLES = 8
) (
   input logic clk,
   input logic rst,
   input logic cu_link_raw,
   input logic fb_link_raw,
   input logic cu_rx_evt,
   input logic fb_err_evt,
   input logic cu_fill_sel,
   input logic fb_fill_sel,
   input logic led_cu_link_n,
   input logic led_fb_link_n,
   input logic led_cu_rx_n,
   input logic led_fb_rx_n,
   input logic led_cu_err_n,
   input logic led_fb_err_n
);
   localparam int unsigned RW = $clog2(STRETCH_CYCLES + 2);

   logic          evt_d;
   logic [RW-1:0] run;

   always_ff @(posedge clk) begin
      if (rst) begin
         evt_d <= 1'b0;
         run   <= '0;
      end else begin
         evt_d <= cu_rx_evt;
         if (!led_cu_rx_n && !evt_d) run <= run + 1'b1;
         else                        run <= '0;
      end
   end

   always @(posedge clk) begin
      if (rst) begin
         assert_lamp_test_R5: assert ({led_cu_link_n, led_fb_link_n, led_cu_rx_n,
                                       led_fb_rx_n, led_cu_err_n, led_fb_err_n} == 6'b0)
            else $error("lamp test broken");
      end
   end

   assert_rx_lights_R2: assert property (@(posedge clk) disable iff (rst)
      cu_rx_evt |=> !led_cu_rx_n);

   assert_err_lights_R4: assert property (@(posedge clk) disable iff (rst)
      fb_err_evt |=> !led_fb_err_n);

   assert_stretch_bound_R3: assert property (@(posedge clk) disable iff (rst)
      (!led_cu_rx_n && !evt_d) |-> (run < RW'(STRETCH_CYCLES - 1)));

   assert_cu_fill_R6: assert property (@(posedge clk) disable iff (rst)
      !$past(fb_link_raw, 2) |-> cu_fill_sel);

   assert_fb_fill_R6: assert property (@(posedge clk) disable iff (rst)
      !$past(cu_link_raw, 2) |-> fb_fill_sel);

   assert_cu_link_off_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(cu_link_raw, 2) |-> led_cu_link_n);

   assert_fb_link_off_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(fb_link_raw, 2) |-> led_fb_link_n);
endmodule

bind media_link_watch mlw_checker #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_mlw_chk (
   .clk(clk), .rst(rst), .cu_link_raw(cu_link_raw), .fb_link_raw(fb_link_raw),
   .cu_rx_evt(cu_rx_evt), .fb_err_evt(fb_err_evt),
   .cu_fill_sel(cu_fill_sel), .fb_fill_sel(fb_fill_sel),
   .led_cu_link_n(led_cu_link_n), .led_fb_link_n(led_fb_link_n),
   .led_cu_rx_n(led_cu_rx_n), .led_fb_rx_n(led_fb_rx_n),
   .led_cu_err_n(led_cu_err_n), .led_fb_err_n(led_fb_err_n)
);

// File: tb/media_link_watch_bench.sv
module media_link_watch_bench;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned N = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cu_link_raw = 1'b0, fb_link_raw = 1'b0;
   logic cu_rx_evt = 1'b0, fb_rx_evt = 1'b0, cu_err_evt = 1'b0, fb_err_evt = 1'b0;
   logic halt_sel = 1'b0;
   logic cu_fill_sel, fb_fill_sel;
   logic [4:0] cu_fill_sym, fb_fill_sym;
   logic led_cu_link_n, led_fb_link_n, led_cu_rx_n, led_fb_rx_n, led_cu_err_n, led_fb_err_n;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   media_link_watch #(.STRETCH_CYCLES(N)) u_media_link_watch (
      .clk(clk), .rst(rst), .cu_link_raw(cu_link_raw), .fb_link_raw(fb_link_raw),
      .cu_rx_evt(cu_rx_evt), .fb_rx_evt(fb_rx_evt), .cu_err_evt(cu_err_evt),
      .fb_err_evt(fb_err_evt), .halt_sel(halt_sel),
      .cu_fill_sel(cu_fill_sel), .cu_fill_sym(cu_fill_sym),
      .fb_fill_sel(fb_fill_sel), .fb_fill_sym(fb_fill_sym),
      .led_cu_link_n(led_cu_link_n), .led_fb_link_n(led_fb_link_n),
      .led_cu_rx_n(led_cu_rx_n), .led_fb_rx_n(led_fb_rx_n),
      .led_cu_err_n(led_cu_err_n), .led_fb_err_n(led_fb_err_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic t_lamp_test();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R5 lamp", {2'b0, led_cu_link_n, led_fb_link_n, led_cu_rx_n, led_fb_rx_n,
                        led_cu_err_n, led_fb_err_n}, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      check("R8 leds off after reset", {2'b0, led_cu_link_n, led_fb_link_n, led_cu_rx_n,
                        led_fb_rx_n, led_cu_err_n, led_fb_err_n}, 8'h3F);
      check("R8 fill after reset", {6'b0, cu_fill_sel, fb_fill_sel}, 8'h03);
   endtask

   // strobe sampled at one edge; return right after that edge
   task automatic strobe_cu_rx();
      cu_rx_evt = 1'b1;
      @(negedge clk);
      cu_rx_evt = 1'b0;
   endtask

   task automatic t_single_stretch();
      @(negedge clk);
      strobe_cu_rx();
      check("R2 lit after edge", {7'b0, led_cu_rx_n}, 8'h00);
      check("R9 fb rx unaffected", {7'b0, led_fb_rx_n}, 8'h01);
      repeat (N - 1) @(negedge clk);
      check("R2 still lit at end", {7'b0, led_cu_rx_n}, 8'h00);
      @(negedge clk);
      check("R2 off after window", {7'b0, led_cu_rx_n}, 8'h01);
   endtask

   task automatic t_retrigger();
      @(negedge clk);
      strobe_cu_rx();
      repeat (3) @(negedge clk);
      strobe_cu_rx();
      repeat (N - 1) @(negedge clk);
      check("R3 held past first window", {7'b0, led_cu_rx_n}, 8'h00);
      @(negedge clk);
      check("R3 off after restarted window", {7'b0, led_cu_rx_n}, 8'h01);
   endtask

   task automatic t_error_led();
      @(negedge clk);
      fb_err_evt = 1'b1;
      @(negedge clk);
      fb_err_evt = 1'b0;
      check("R4 fb err lit", {7'b0, led_fb_err_n}, 8'h00);
      check("R9 cu err unaffected", {7'b0, led_cu_err_n}, 8'h01);
      repeat (N - 1) @(negedge clk);
      check("R4 fb err still lit", {7'b0, led_fb_err_n}, 8'h00);
      @(negedge clk);
      check("R4 fb err off", {7'b0, led_fb_err_n}, 8'h01);
   endtask

   task automatic t_links();
      @(negedge clk);
      fb_link_raw = 1'b1;
      @(negedge clk);
      check("R1 fb link not yet", {7'b0, led_fb_link_n}, 8'h01);
      check("R6 cu fill still on", {7'b0, cu_fill_sel}, 8'h01);
      @(negedge clk);
      check("R1 fb link LED on", {7'b0, led_fb_link_n}, 8'h00);
      check("R6 cu fill released", {7'b0, cu_fill_sel}, 8'h00);
      check("R9 cu link LED off", {7'b0, led_cu_link_n}, 8'h01);
      check("R6 fb fill on", {7'b0, fb_fill_sel}, 8'h01);
      cu_link_raw = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 cu link LED on", {7'b0, led_cu_link_n}, 8'h00);
      check("R6 fb fill released", {7'b0, fb_fill_sel}, 8'h00);
      fb_link_raw = 1'b0;
      repeat (2) @(negedge clk);
      check("R6 cu fill after fb loss", {7'b0, cu_fill_sel}, 8'h01);
      check("R1 fb link LED off", {7'b0, led_fb_link_n}, 8'h01);
   endtask

   task automatic t_fill_codes();
      halt_sel = 1'b0;
      @(negedge clk);
      check("R7 idle cu", {3'b0, cu_fill_sym}, 8'h1F);
      check("R7 idle fb", {3'b0, fb_fill_sym}, 8'h1F);
      halt_sel = 1'b1;
      @(negedge clk);
      check("R7 halt cu", {3'b0, cu_fill_sym}, 8'h04);
      check("R7 halt fb", {3'b0, fb_fill_sym}, 8'h04);
   endtask

   initial begin
      t_lamp_test();
      t_single_stretch();
      t_retrigger();
      t_error_led();
      t_links();
      t_fill_codes();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule